// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a successive-approximation converter. On a hardware trigger, normally the update event of a PWM timer, it selects an analog channel and closes the sample switch for a fixed number of cycles. It then runs a binary search against an external comparator. Each cycle it presents a DAC code with one trial bit set. On the next clock edge it keeps that bit when the comparator reports the input at or above the code, and clears it otherwise. Bits are settled from the most significant bit downwards, one per cycle.

The block has two ways of running. In regular mode, one trigger gives one conversion on one channel, and the result goes into a single 16-bit data register. In injected mode, one trigger runs a queued list of one to four channels back to back, and each result lands in the slot matching its position in the list. The resolution can be 12, 10 or 8 bits. Each result is placed right-aligned or left-aligned in its 16-bit register.

A pulse marks every stored result, and another pulse marks the end of an injected list. The block captures its configuration at the trigger. A trigger that arrives while the block is busy is dropped, and an overrun pulse reports it.

Top module: `sar_seq_top`

## Requirements
- R1: A trigger seen while idle makes `busy` and `sample_en` high from the next cycle. `sample_en` then stays high for exactly SMP_CYC cycles, and `chan_sel` holds the selected channel throughout.
- R2: During conversion the trial bit moves down by one position per cycle, starting at bit RES_MAX-1. Each bit above the trial bit carries the comparator value sampled when that bit was on trial.
- R3: The stored value is floor(vin / 2^(12-N)), where vin is the 12-bit level that the comparator resolves. N comes from `res_sel`: 0 gives 12 bits, 1 gives 10 bits, and 2 or 3 give 8 bits.
- R4: With `align_left`=0 the N-bit value occupies bits N-1..0. With `align_left`=1 it occupies bits 15..16-N. All other bits are zero.
- R5: `eoc` rises on the clock edge that comes SMP_CYC+N edges after the edge that captured the trigger.
- R6: In regular mode (`mode_inj`=0) a trigger gives exactly one conversion of `reg_chan`. It updates `reg_data`, gives a single one-cycle `eoc`, and leaves `busy` low afterwards. `inj_data` does not change.
- R7: In injected mode, `inj_len` (0..3) selects 1..4 conversions. Position k uses channel `inj_chans[5k+4:5k]` and writes slot k, which is `inj_data[16k+15:16k]`. `reg_data` and the slots beyond the list length keep their values.
- R8: `eos` pulses only together with the `eoc` of the last position of an injected list. It never pulses in regular mode.
- R9: A trigger while `busy` is high does not change the running conversion, its result or its timing. `ovr` is high in the following cycle. A trigger while idle leaves `ovr` low.
- R10: After reset, `busy`, `sample_en`, `eoc`, `eos` and `ovr` are low, and `dac_code`, `reg_data` and `inj_data` are zero.
- R11: Mode, resolution, alignment and channel inputs are captured at the accepted trigger. Changes to them while busy do not affect that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Hardware start trigger (timer update event) |
| mode_inj | input | 1 | 0 = regular single conversion, 1 = injected list |
| res_sel | input | 2 | Resolution: 0 = 12, 1 = 10, 2/3 = 8 bits |
| align_left | input | 1 | 1 = left-align result, 0 = right-align |
| reg_chan | input | 5 | Channel for regular mode |
| inj_len | input | 2 | Injected list length minus one |
| inj_chans | input | 20 | Four 5-bit channel numbers, position 0 in the low bits |
| cmp_in | input | 1 | Comparator: 1 when input is at or above `dac_code` |
| dac_code | output | 12 | Trial code for the DAC, zero when not converting |
| sample_en | output | 1 | Sample switch closed |
| chan_sel | output | 5 | Selected analog channel |
| busy | output | 1 | Sampling or converting |
| reg_data | output | 16 | Regular result register |
| inj_data | output | 64 | Four injected result slots, slot 0 in the low bits |
| eoc | output | 1 | One-cycle pulse after each stored result |
| eos | output | 1 | One-cycle pulse after the last injected result |
| ovr | output | 1 | One-cycle pulse after a trigger that arrived while busy |

## Verification
The bench builds the block with SMP_CYC=2 and the default 12-bit core, 16-bit registers and four injected slots. The short sampling window keeps each conversion near 15 cycles. That brings a sweep of all four resolution codes and both alignments, over 67 input levels each, well within the cycle budget, and every result is compared with a value computed by shifting. With four slots, every list length from one to four can be run under every resolution and alignment. Each run checks the slot contents, the untouched slots and the placement of `eos`. A trigger injected mid-conversion, together with changed mode and resolution inputs, checks that overruns are dropped and that the configuration is captured at the accepted trigger.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } sar_state_e;

  // Each step of the resolution code drops this many bits.
  localparam int unsigned RES_STEP = 2;

  // Number of resolved bits for a resolution code.
  function automatic int unsigned res_bits(input logic [1:0] sel, input int unsigned full);
    unique case (sel)
      2'd0:    return full;
      2'd1:    return full - RES_STEP;
      default: return full - 2 * RES_STEP;
    endcase
  endfunction

endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_pkg::*;
#(
  parameter int SMP_CYC = 3,
  parameter int CH_W    = 5,
  parameter int INJ_MAX = 4,
  parameter int LEN_W   = (INJ_MAX > 1) ? $clog2(INJ_MAX) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig_i,
  input  logic                    mode_inj_i,
  input  logic [1:0]              res_sel_i,
  input  logic                    align_left_i,
  input  logic [CH_W-1:0]         reg_chan_i,
  input  logic [LEN_W-1:0]        inj_len_i,
  input  logic [INJ_MAX*CH_W-1:0] inj_chans_i,
  input  logic                    conv_fin_i,
  output logic                    start_o,
  output logic                    sample_o,
  output logic                    busy_o,
  output logic [CH_W-1:0]         chan_o,
  output logic [LEN_W-1:0]        seq_o,
  output logic                    inj_o,
  output logic [1:0]              res_sel_o,
  output logic                    left_o,
  output logic                    last_o,
  output logic                    ovr_o
);

  localparam int SC_W = (SMP_CYC > 1) ? $clog2(SMP_CYC) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(SMP_CYC - 1);

  sar_state_e              state_q;
  logic [SC_W-1:0]         smp_cnt_q;
  logic [LEN_W-1:0]        seq_q;
  logic                    cfg_inj_q;
  logic [1:0]              cfg_res_q;
  logic                    cfg_left_q;
  logic [CH_W-1:0]         cfg_chan_q;
  logic [LEN_W-1:0]        cfg_len_q;
  logic [INJ_MAX*CH_W-1:0] cfg_list_q;

  // Named events for the assertions.
  logic accept_w;
  logic smp_last_w;
  logic more_w;

  assign accept_w   = trig_i && (state_q == ST_IDLE);
  assign smp_last_w = (state_q == ST_SAMPLE) && (smp_cnt_q == SC_LAST);
  assign more_w     = cfg_inj_q && (seq_q != cfg_len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      smp_cnt_q  <= '0;
      seq_q      <= '0;
      cfg_inj_q  <= 1'b0;
      cfg_res_q  <= 2'd0;
      cfg_left_q <= 1'b0;
      cfg_chan_q <= '0;
      cfg_len_q  <= '0;
      cfg_list_q <= '0;
      ovr_o      <= 1'b0;
    end else begin
      ovr_o <= trig_i && (state_q != ST_IDLE);
      unique case (state_q)
        ST_IDLE: begin
          if (trig_i) begin
            cfg_inj_q  <= mode_inj_i;
            cfg_res_q  <= res_sel_i;
            cfg_left_q <= align_left_i;
            cfg_chan_q <= reg_chan_i;
            cfg_len_q  <= inj_len_i;
            cfg_list_q <= inj_chans_i;
            seq_q      <= '0;
            smp_cnt_q  <= '0;
            state_q    <= ST_SAMPLE;
          end
        end
        ST_SAMPLE: begin
          if (smp_last_w) begin
            smp_cnt_q <= '0;
            state_q   <= ST_CONV;
          end else begin
            smp_cnt_q <= smp_cnt_q + 1'b1;
          end
        end
        ST_CONV: begin
          if (conv_fin_i) begin
            if (more_w) begin
              seq_q     <= seq_q + 1'b1;
              smp_cnt_q <= '0;
              state_q   <= ST_SAMPLE;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign start_o   = smp_last_w;
  assign sample_o  = (state_q == ST_SAMPLE);
  assign busy_o    = (state_q != ST_IDLE);
  assign chan_o    = cfg_inj_q ? cfg_list_q[int'(seq_q)*CH_W +: CH_W] : cfg_chan_q;
  assign seq_o     = seq_q;
  assign inj_o     = cfg_inj_q;
  assign res_sel_o = cfg_res_q;
  assign left_o    = cfg_left_q;
  assign last_o    = !more_w;

  p_busy_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (sample_o && busy_o));

  p_chan_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && $past(sample_o)) |-> $stable(chan_o));

  p_ovr_on_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && busy_o) |=> ovr_o);

  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(res_sel_o) && $stable(inj_o) && $stable(left_o)));

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
  import sar_pkg::*;
#(
  parameter int RES_MAX = 12,
  parameter int IDX_W   = $clog2(RES_MAX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         res_sel_i,
  input  logic               cmp_i,
  output logic [RES_MAX-1:0] dac_code_o,
  output logic               conv_fin_o,
  output logic [RES_MAX-1:0] code_fin_o
);

  logic               active_q;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   stop_q;
  logic [RES_MAX-1:0] acc_q;
  logic [RES_MAX-1:0] trial_w;
  logic [IDX_W-1:0]   stop_w;

  assign trial_w    = RES_MAX'(1) << idx_q;
  assign stop_w     = IDX_W'(RES_MAX - int'(res_bits(res_sel_i, RES_MAX)));
  assign dac_code_o = active_q ? (acc_q | trial_w) : '0;
  assign code_fin_o = cmp_i ? (acc_q | trial_w) : acc_q;
  assign conv_fin_o = active_q && (idx_q == stop_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      stop_q   <= '0;
      acc_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= IDX_W'(RES_MAX - 1);
      stop_q   <= stop_w;
      acc_q    <= '0;
    end else if (active_q) begin
      acc_q <= code_fin_o;
      if (conv_fin_o) active_q <= 1'b0;
      else            idx_q    <= idx_q - 1'b1;
    end
  end

  p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q)) |-> (idx_q == IDX_W'($past(idx_q) - 1'b1)));

  p_kept_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q)) |-> (dac_code_o[int'(idx_q) + 1] == $past(cmp_i)));

  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !active_q);

endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank
  import sar_pkg::*;
#(
  parameter int RES_MAX = 12,
  parameter int DATA_W  = 16,
  parameter int INJ_MAX = 4,
  parameter int LEN_W   = (INJ_MAX > 1) ? $clog2(INJ_MAX) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      conv_fin_i,
  input  logic [RES_MAX-1:0]        code_i,
  input  logic [1:0]                res_sel_i,
  input  logic                      left_i,
  input  logic                      inj_i,
  input  logic [LEN_W-1:0]          seq_i,
  input  logic                      last_i,
  output logic [DATA_W-1:0]         reg_data_o,
  output logic [INJ_MAX*DATA_W-1:0] inj_data_o,
  output logic                      eoc_o,
  output logic                      eos_o
);

  // Code arrives MSB-justified in RES_MAX bits with unused low bits zero.
  function automatic logic [DATA_W-1:0] place(input logic [RES_MAX-1:0] code,
                                              input logic [1:0] sel,
                                              input logic left);
    logic [DATA_W-1:0] wide;
    int unsigned       nb;
    nb   = res_bits(sel, RES_MAX);
    wide = DATA_W'(code);
    if (left) return wide << (DATA_W - RES_MAX);
    return wide >> (RES_MAX - int'(nb));
  endfunction

  logic [DATA_W-1:0] placed_w;
  logic              wr_reg_w;

  assign placed_w = place(code_i, res_sel_i, left_i);
  assign wr_reg_w = conv_fin_i && !inj_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_data_o <= '0;
      eoc_o      <= 1'b0;
      eos_o      <= 1'b0;
    end else begin
      eoc_o <= conv_fin_i;
      eos_o <= conv_fin_i && inj_i && last_i;
      if (wr_reg_w) reg_data_o <= placed_w;
    end
  end

  for (genvar k = 0; k < INJ_MAX; k++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              wr_w;
    assign wr_w = conv_fin_i && inj_i && (int'(seq_i) == k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    slot_q <= '0;
      else if (wr_w) slot_q <= placed_w;
    end
    assign inj_data_o[k*DATA_W +: DATA_W] = slot_q;
  end

  p_eos_with_eoc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eos_o |-> eoc_o);

  p_eoc_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |=> !eoc_o);

  p_reg_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_fin_i && inj_i) |=> $stable(reg_data_o));

  p_no_eos_regular_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_fin_i && !inj_i) |=> !eos_o);

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_pkg::*;
#(
  parameter int SMP_CYC = 3,
  parameter int RES_MAX = 12,
  parameter int DATA_W  = 16,
  parameter int INJ_MAX = 4,
  parameter int CH_W    = 5,
  localparam int LEN_W  = (INJ_MAX > 1) ? $clog2(INJ_MAX) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      trig,
  input  logic                      mode_inj,
  input  logic [1:0]                res_sel,
  input  logic                      align_left,
  input  logic [CH_W-1:0]           reg_chan,
  input  logic [LEN_W-1:0]          inj_len,
  input  logic [INJ_MAX*CH_W-1:0]   inj_chans,
  input  logic                      cmp_in,
  output logic [RES_MAX-1:0]        dac_code,
  output logic                      sample_en,
  output logic [CH_W-1:0]           chan_sel,
  output logic                      busy,
  output logic [DATA_W-1:0]         reg_data,
  output logic [INJ_MAX*DATA_W-1:0] inj_data,
  output logic                      eoc,
  output logic                      eos,
  output logic                      ovr
);

  logic               start_w;
  logic               conv_fin_w;
  logic [RES_MAX-1:0] code_fin_w;
  logic [LEN_W-1:0]   seq_w;
  logic               inj_w;
  logic [1:0]         res_w;
  logic               left_w;
  logic               last_w;

  sar_seq_fsm #(
    .SMP_CYC(SMP_CYC), .CH_W(CH_W), .INJ_MAX(INJ_MAX), .LEN_W(LEN_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .mode_inj_i(mode_inj),
    .res_sel_i(res_sel), .align_left_i(align_left), .reg_chan_i(reg_chan),
    .inj_len_i(inj_len), .inj_chans_i(inj_chans), .conv_fin_i(conv_fin_w),
    .start_o(start_w), .sample_o(sample_en), .busy_o(busy), .chan_o(chan_sel),
    .seq_o(seq_w), .inj_o(inj_w), .res_sel_o(res_w), .left_o(left_w),
    .last_o(last_w), .ovr_o(ovr)
  );

  sar_bit_engine #(.RES_MAX(RES_MAX)) u_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .res_sel_i(res_w),
    .cmp_i(cmp_in), .dac_code_o(dac_code), .conv_fin_o(conv_fin_w),
    .code_fin_o(code_fin_w)
  );

  sar_result_bank #(
    .RES_MAX(RES_MAX), .DATA_W(DATA_W), .INJ_MAX(INJ_MAX), .LEN_W(LEN_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .conv_fin_i(conv_fin_w), .code_i(code_fin_w),
    .res_sel_i(res_w), .left_i(left_w), .inj_i(inj_w), .seq_i(seq_w),
    .last_i(last_w), .reg_data_o(reg_data), .inj_data_o(inj_data),
    .eoc_o(eoc), .eos_o(eos)
  );

  p_dac_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_code == '0));

endmodule

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;

  localparam int SMP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        mode_inj = 1'b0;
  logic [1:0]  res_sel = 2'd0;
  logic        align_left = 1'b0;
  logic [4:0]  reg_chan = '0;
  logic [1:0]  inj_len = '0;
  logic [19:0] inj_chans = '0;
  logic        cmp_in;
  logic [11:0] dac_code;
  logic        sample_en;
  logic [4:0]  chan_sel;
  logic        busy;
  logic [15:0] reg_data;
  logic [63:0] inj_data;
  logic        eoc, eos, ovr;

  logic [11:0] vin_tab [32];
  logic [15:0] reg_shadow = '0;
  logic [63:0] inj_shadow = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  // Comparator model: high when the channel level is at or above the DAC code.
  assign cmp_in = (vin_tab[chan_sel] >= dac_code);

  sar_seq_top #(.SMP_CYC(SMP)) dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .mode_inj(mode_inj),
    .res_sel(res_sel), .align_left(align_left), .reg_chan(reg_chan),
    .inj_len(inj_len), .inj_chans(inj_chans), .cmp_in(cmp_in),
    .dac_code(dac_code), .sample_en(sample_en), .chan_sel(chan_sel),
    .busy(busy), .reg_data(reg_data), .inj_data(inj_data),
    .eoc(eoc), .eos(eos), .ovr(ovr)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic int nbits(input int rs);
    return (rs == 0) ? 12 : (rs == 1) ? 10 : 8;
  endfunction

  function automatic logic [15:0] expect_val(input int v, input int rs, input bit lf);
    int n, q;
    n = nbits(rs);
    q = v / (1 << (12 - n));
    return lf ? 16'(q * (1 << (16 - n))) : 16'(q);
  endfunction

  task automatic run_reg(input int ch, input int v, input int rs, input bit lf);
    int cnt, smp, n;
    bit seen_eos, seen_ovr;
    n = nbits(rs);
    vin_tab[ch] = 12'(v);
    reg_chan = 5'(ch); res_sel = 2'(rs); align_left = lf; mode_inj = 1'b0;
    trig = 1'b1;
    cnt = 0; smp = 0; seen_eos = 0; seen_ovr = 0;
    do begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (cnt == 1) begin
        trig = 1'b0;
        chk(busy && sample_en && (chan_sel == 5'(ch)), "R1 start/channel", {busy, sample_en, chan_sel}, {2'b11, 5'(ch)});
      end
      if (sample_en) smp++;
      if (eos) seen_eos = 1;
      if (ovr) seen_ovr = 1;
    end while (!eoc && cnt < 100);
    chk(cnt == SMP + n + 1, "R5 latency", cnt, SMP + n + 1);
    chk(smp == SMP, "R1 sample length", smp, SMP);
    chk(reg_data == expect_val(v, rs, lf), "R3 R4 regular result", reg_data, expect_val(v, rs, lf));
    chk(!seen_eos, "R8 no eos in regular", seen_eos, 0);
    chk(!seen_ovr, "R9 no ovr when idle", seen_ovr, 0);
    chk(!busy, "R6 idle after eoc", busy, 0);
    reg_shadow = expect_val(v, rs, lf);
    @(posedge clk); @(negedge clk);
    chk(!eoc && !busy, "R6 single eoc", {eoc, busy}, 0);
    chk(inj_data == inj_shadow, "R6 injected slots untouched", inj_data, inj_shadow);
  endtask

  task automatic run_inj(input int len, input int rs, input bit lf, input int seed);
    int ch [4];
    logic [15:0] ev;
    for (int k = 0; k < 4; k++) begin
      ch[k] = (seed * 5 + k * 9 + 1) % 32;
      inj_chans[k*5 +: 5] = 5'(ch[k]);
    end
    for (int i = 0; i < 32; i++) vin_tab[i] = 12'((i * 797 + seed * 131 + 5) % 4096);
    mode_inj = 1'b1; inj_len = 2'(len); res_sel = 2'(rs); align_left = lf;
    trig = 1'b1;
    @(posedge clk); @(negedge clk);
    trig = 1'b0;
    chk(busy && chan_sel == 5'(ch[0]), "R7 injected start channel", chan_sel, ch[0]);
    for (int k = 0; k <= len; k++) begin
      int guard = 0;
      do begin
        @(posedge clk); @(negedge clk); guard++;
      end while (!eoc && guard < 100);
      ev = expect_val(int'(vin_tab[ch[k]]), rs, lf);
      inj_shadow[k*16 +: 16] = ev;
      chk(inj_data[k*16 +: 16] == ev, "R7 injected slot value", inj_data[k*16 +: 16], ev);
      chk(eos == (k == len), "R8 eos placement", eos, (k == len));
      chk(reg_data == reg_shadow, "R7 regular register kept", reg_data, reg_shadow);
    end
    @(posedge clk); @(negedge clk);
    chk(!busy && !eoc, "R7 idle after list", {busy, eoc}, 0);
    chk(inj_data == inj_shadow, "R7 slots beyond length kept", inj_data, inj_shadow);
  endtask

  task automatic run_overrun();
    int cnt;
    bit seen_eos;
    vin_tab[3] = 12'd2500;
    reg_chan = 5'd3; res_sel = 2'd0; align_left = 1'b0; mode_inj = 1'b0;
    trig = 1'b1;
    cnt = 0; seen_eos = 0;
    do begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (cnt == 1) trig = 1'b0;
      if (cnt == SMP + 3) begin
        trig = 1'b1; mode_inj = 1'b1; res_sel = 2'd2; align_left = 1'b1; reg_chan = 5'd7;
      end
      if (cnt == SMP + 4) begin
        trig = 1'b0;
        chk(ovr, "R9 overrun pulse", ovr, 1);
      end
      if (cnt == SMP + 5) chk(!ovr, "R9 overrun one cycle", ovr, 0);
      if (eos) seen_eos = 1;
    end while (!eoc && cnt < 100);
    chk(cnt == SMP + 13, "R9 timing kept", cnt, SMP + 13);
    chk(reg_data == 16'd2500, "R11 captured config result", reg_data, 2500);
    chk(!seen_eos, "R9 no injected run", seen_eos, 0);
    chk(inj_data == inj_shadow, "R9 slots untouched", inj_data, inj_shadow);
    reg_shadow = 16'd2500;
    @(posedge clk); @(negedge clk);
    chk(!busy, "R9 idle after", busy, 0);
    mode_inj = 1'b0; res_sel = 2'd0; align_left = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) vin_tab[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !sample_en && !eoc && !eos && !ovr, "R10 reset flags", {busy, sample_en, eoc, eos, ovr}, 0);
    chk(reg_data == 0 && inj_data == 0 && dac_code == 0, "R10 reset data", reg_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && reg_data == 0, "R10 after release", busy, 0);

    run_reg(0, 0, 0, 0);
    run_reg(31, 4095, 0, 0);
    run_reg(5, 4095, 2, 1);
    for (int rs = 0; rs < 4; rs++) begin
      for (int lf = 0; lf < 2; lf++) begin
        for (int k = 0; k < 64; k++) begin
          run_reg(k % 32, (k * 65 + rs * 7 + lf) % 4096, rs, lf[0]);
        end
        run_reg(1, 2048, rs, lf[0]);
        run_reg(2, 2047, rs, lf[0]);
        run_reg(4, 1, rs, lf[0]);
      end
    end

    for (int len = 0; len < 4; len++)
      for (int rs = 0; rs < 4; rs++)
        for (int lf = 0; lf < 2; lf++)
          run_inj(len, rs, lf[0], len * 8 + rs * 2 + lf);

    run_overrun();
    run_reg(9, 1234, 1, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule